// File: doc/BRIEF.md
# Scoreboard Hazard Controller

This block is the central hazard bookkeeper for a machine that issues instructions in program order but lets them execute and finish out of order across a small set of functional units. The default configuration has five units: an integer unit, an adder, two multipliers and a divider. The block keeps one status slot per unit. Each slot holds the destination and source register numbers, the unit expected to produce each source, and a ready flag for each operand. A table indexed by register number records which unit will next write each register.

Each instruction moves through four steps: issue, operand read, execution, and result write. Issue is refused while the target unit is occupied or while an instruction in flight already targets the same destination register. A refused instruction must be held at the input, and nothing behind it may issue. Operands are read only from the register file, with no forwarding, and only when both of them are valid. Units signal the end of execution with a strobe. A finished unit writes its result once no older instruction still needs to read the register's previous value. One unit may read operands per cycle, because the two input buses carry both of its operands together. One unit may write per cycle over the single output bus.

Top module: `scoreboard_ctl`

## Requirements
- R1: After reset every unit is idle and no register is pending. With no request presented, `iss_stall`, `rd_grant` and `wr_grant` are all zero.
- R2: A presented instruction is stalled (`iss_stall`=1) while its requested unit `iss_unit` is busy. `iss_stall` is never high without `iss_valid`.
- R3: A presented instruction is stalled while any instruction in flight has the same destination register. It is accepted in the cycle after that older instruction's write grant.
- R4: A stalled instruction leaves no trace. The requested unit receives no grant for it, and the same instruction is accepted unchanged once the blocking condition clears.
- R5: A unit is granted its operand read only once neither source is awaiting an unwritten result from another unit. When a producer is granted its write in cycle t, a consumer that is waiting only on that producer is granted its read in cycle t+1.
- R6: At most one unit holds `rd_grant` per cycle, and the lowest-numbered eligible unit wins. A unit reads only once per instruction. An accepted instruction whose sources are ready reads in the cycle after issue at the earliest.
- R7: A `unit_done` strobe in cycle t for a unit that has read its operands makes that unit eligible to write in cycle t+1. A strobe for a unit that is idle, or that has not yet read its operands, is ignored.
- R8: A finished unit is denied the write while another busy unit has a ready, still-unread source equal to the finished unit's destination register.
- R9: At most one unit holds `wr_grant` per cycle, and the lowest-numbered eligible unit wins. `wr_reg` carries the granted unit's destination register.
- R10: A unit's busy state ends with its write grant. A new instruction for that unit is stalled in the write cycle and accepted in the next cycle.
- R11: An instruction accepted in the same cycle that its source's producer is granted the write treats that source as ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | An instruction is presented for issue |
| iss_unit | input | FU_W | Functional unit the instruction needs |
| iss_dst | input | REG_W | Destination register number |
| iss_src_a | input | REG_W | First source register number |
| iss_src_b | input | REG_W | Second source register number |
| iss_stall | output | 1 | Presented instruction is refused this cycle and must be held |
| unit_done | input | NUM_FU | Per-unit end-of-execution strobe |
| rd_grant | output | NUM_FU | Per-unit permission to read both operands this cycle |
| wr_grant | output | NUM_FU | Per-unit permission to write its result this cycle |
| wr_reg | output | REG_W | Register written by the granted unit |

## Verification
Directed sequences target each hazard on its own. A dependent add waits on a multiply, which separates a read that is held for a true dependence from one released early. A repeated destination separates refusal for a destination conflict from refusal for a busy unit. A consumer that still holds an unread copy of a register blocks a finished writer, which shows whether the anti-dependence check is present at all. Several units that become ready or finish in the same cycle expose the bus limit and the priority order. A constrained-random stream over only eight registers and five units then produces dense overlapping hazards. Every cycle of that stream is compared against a behavioural model written from the requirements, which catches errors in the same-cycle interaction of issue, read and write.

// File: rtl/sb_pkg.sv
package sb_pkg;

  // Life cycle of one functional-unit slot
  typedef enum logic [1:0] {
    SLOT_IDLE = 2'd0,  // no instruction held
    SLOT_WAIT = 2'd1,  // issued, waiting for operands
    SLOT_EXEC = 2'd2,  // operands read, unit executing
    SLOT_DONE = 2'd3   // finished, waiting for the write bus
  } slot_phase_e;

endpackage

// File: rtl/sb_lowest_pick.sv
module sb_lowest_pick #(
  parameter int N = 5
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);

  logic taken;

  always_comb begin
    gnt   = '0;
    taken = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !taken) begin
        gnt[i] = 1'b1;
        taken  = 1'b1;
      end
    end
  end

endmodule

// File: rtl/sb_result_table.sv
module sb_result_table #(
  parameter int FU_W  = 3,
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [REG_W-1:0] set_reg,
  input  logic [FU_W-1:0]  set_tag,
  input  logic             clr_en,
  input  logic [REG_W-1:0] clr_reg,
  input  logic [REG_W-1:0] look_a,
  input  logic [REG_W-1:0] look_b,
  input  logic [REG_W-1:0] look_d,
  output logic             look_a_pend,
  output logic [FU_W-1:0]  look_a_tag,
  output logic             look_b_pend,
  output logic [FU_W-1:0]  look_b_tag,
  output logic             look_d_pend
);

  localparam int SPAN = 1 << REG_W;

  logic [SPAN-1:0] pend_q, pend_nxt;
  logic [FU_W-1:0] tag_q [SPAN];

  always_comb begin
    pend_nxt = pend_q;
    if (clr_en) pend_nxt[clr_reg] = 1'b0;
    if (set_en) pend_nxt[set_reg] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SPAN; i++) tag_q[i] <= '0;
    end else if (set_en) begin
      tag_q[set_reg] <= set_tag;
    end
  end

  assign look_a_pend = pend_q[look_a];
  assign look_a_tag  = tag_q[look_a];
  assign look_b_pend = pend_q[look_b];
  assign look_b_tag  = tag_q[look_b];
  assign look_d_pend = pend_q[look_d];

endmodule

// File: rtl/sb_unit_slot.sv
module sb_unit_slot
  import sb_pkg::*;
#(
  parameter int FU_W  = 3,
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [REG_W-1:0] ld_dst,
  input  logic [REG_W-1:0] ld_src_a,
  input  logic [REG_W-1:0] ld_src_b,
  input  logic [FU_W-1:0]  ld_tag_a,
  input  logic [FU_W-1:0]  ld_tag_b,
  input  logic             ld_rdy_a,
  input  logic             ld_rdy_b,
  input  logic             rd_gnt,
  input  logic             exec_done,
  input  logic             wr_gnt,
  input  logic             bc_valid,
  input  logic [FU_W-1:0]  bc_tag,
  output logic             busy,
  output logic [REG_W-1:0] dst,
  output logic [REG_W-1:0] src_a,
  output logic [REG_W-1:0] src_b,
  output logic             rdy_a,
  output logic             rdy_b,
  output logic             rd_req,
  output logic             wr_req
);

  slot_phase_e      phase_q, phase_d;
  logic             rdy_a_q, rdy_a_d, rdy_b_q, rdy_b_d;
  logic [REG_W-1:0] dst_q, src_a_q, src_b_q;
  logic [FU_W-1:0]  tag_a_q, tag_b_q;
  logic             waiting;

  assign waiting = (phase_q == SLOT_WAIT);

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      SLOT_IDLE: if (load)      phase_d = SLOT_WAIT;
      SLOT_WAIT: if (rd_gnt)    phase_d = SLOT_EXEC;
      SLOT_EXEC: if (exec_done) phase_d = SLOT_DONE;
      SLOT_DONE: if (wr_gnt)    phase_d = SLOT_IDLE;
    endcase
  end

  always_comb begin
    rdy_a_d = rdy_a_q;
    rdy_b_d = rdy_b_q;
    if (load) begin
      rdy_a_d = ld_rdy_a;
      rdy_b_d = ld_rdy_b;
    end else if (rd_gnt) begin
      rdy_a_d = 1'b0;
      rdy_b_d = 1'b0;
    end else begin
      if (waiting && !rdy_a_q && bc_valid && (tag_a_q == bc_tag)) rdy_a_d = 1'b1;
      if (waiting && !rdy_b_q && bc_valid && (tag_b_q == bc_tag)) rdy_b_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= SLOT_IDLE;
      rdy_a_q <= 1'b0;
      rdy_b_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
      rdy_a_q <= rdy_a_d;
      rdy_b_q <= rdy_b_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dst_q   <= '0;
      src_a_q <= '0;
      src_b_q <= '0;
      tag_a_q <= '0;
      tag_b_q <= '0;
    end else if (load) begin
      dst_q   <= ld_dst;
      src_a_q <= ld_src_a;
      src_b_q <= ld_src_b;
      tag_a_q <= ld_tag_a;
      tag_b_q <= ld_tag_b;
    end
  end

  assign busy   = (phase_q != SLOT_IDLE);
  assign dst    = dst_q;
  assign src_a  = src_a_q;
  assign src_b  = src_b_q;
  assign rdy_a  = rdy_a_q;
  assign rdy_b  = rdy_b_q;
  assign rd_req = waiting && rdy_a_q && rdy_b_q;
  assign wr_req = (phase_q == SLOT_DONE);

endmodule

// File: rtl/scoreboard_ctl.sv
module scoreboard_ctl
  import sb_pkg::*;
#(
  parameter  int NUM_FU  = 5,
  parameter  int NUM_REG = 32,
  localparam int FU_W    = (NUM_FU > 1) ? $clog2(NUM_FU) : 1,
  localparam int REG_W   = $clog2(NUM_REG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iss_valid,
  input  logic [FU_W-1:0]   iss_unit,
  input  logic [REG_W-1:0]  iss_dst,
  input  logic [REG_W-1:0]  iss_src_a,
  input  logic [REG_W-1:0]  iss_src_b,
  output logic              iss_stall,
  input  logic [NUM_FU-1:0] unit_done,
  output logic [NUM_FU-1:0] rd_grant,
  output logic [NUM_FU-1:0] wr_grant,
  output logic [REG_W-1:0]  wr_reg
);

  localparam int FU_SPAN = 1 << FU_W;

  logic [NUM_FU-1:0]  busy_v, rdy_a_v, rdy_b_v, rd_req_v, fin_v, war_ok_v, load_v;
  logic [REG_W-1:0]   dst_arr [NUM_FU];
  logic [REG_W-1:0]   sa_arr  [NUM_FU];
  logic [REG_W-1:0]   sb_arr  [NUM_FU];
  logic [FU_SPAN-1:0] busy_pad;
  logic               pend_a, pend_b, pend_d;
  logic [FU_W-1:0]    tag_a, tag_b;
  logic               rdy_a_iss, rdy_b_iss, issue_ok;
  logic               wr_any;
  logic [FU_W-1:0]    wr_idx;

  // Unit occupancy, indices beyond the unit count read as busy
  always_comb begin
    busy_pad = '1;
    for (int i = 0; i < NUM_FU; i++) busy_pad[i] = busy_v[i];
  end

  assign issue_ok  = iss_valid && !busy_pad[iss_unit] && !pend_d;
  assign iss_stall = iss_valid && !issue_ok;

  // A source whose producer writes this very cycle counts as ready
  assign rdy_a_iss = !pend_a || (wr_any && (tag_a == wr_idx));
  assign rdy_b_iss = !pend_b || (wr_any && (tag_b == wr_idx));

  sb_result_table #(.FU_W(FU_W), .REG_W(REG_W)) u_rtab (
    .clk         (clk),
    .rst_n       (rst_n),
    .set_en      (issue_ok),
    .set_reg     (iss_dst),
    .set_tag     (iss_unit),
    .clr_en      (wr_any),
    .clr_reg     (wr_reg),
    .look_a      (iss_src_a),
    .look_b      (iss_src_b),
    .look_d      (iss_dst),
    .look_a_pend (pend_a),
    .look_a_tag  (tag_a),
    .look_b_pend (pend_b),
    .look_b_tag  (tag_b),
    .look_d_pend (pend_d)
  );

  for (genvar g = 0; g < NUM_FU; g++) begin : g_slot
    assign load_v[g] = issue_ok && (iss_unit == FU_W'(g));

    sb_unit_slot #(.FU_W(FU_W), .REG_W(REG_W)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load_v[g]),
      .ld_dst    (iss_dst),
      .ld_src_a  (iss_src_a),
      .ld_src_b  (iss_src_b),
      .ld_tag_a  (tag_a),
      .ld_tag_b  (tag_b),
      .ld_rdy_a  (rdy_a_iss),
      .ld_rdy_b  (rdy_b_iss),
      .rd_gnt    (rd_grant[g]),
      .exec_done (unit_done[g]),
      .wr_gnt    (wr_grant[g]),
      .bc_valid  (wr_any),
      .bc_tag    (wr_idx),
      .busy      (busy_v[g]),
      .dst       (dst_arr[g]),
      .src_a     (sa_arr[g]),
      .src_b     (sb_arr[g]),
      .rdy_a     (rdy_a_v[g]),
      .rdy_b     (rdy_b_v[g]),
      .rd_req    (rd_req_v[g]),
      .wr_req    (fin_v[g])
    );
  end

  // Anti-dependence: a finished unit waits while any other unit still
  // holds a ready but unread copy of its destination register
  always_comb begin
    for (int u = 0; u < NUM_FU; u++) begin
      war_ok_v[u] = 1'b1;
      for (int f = 0; f < NUM_FU; f++) begin
        if ((f != u) && busy_v[f]) begin
          if (((sa_arr[f] == dst_arr[u]) && rdy_a_v[f]) ||
              ((sb_arr[f] == dst_arr[u]) && rdy_b_v[f]))
            war_ok_v[u] = 1'b0;
        end
      end
    end
  end

  sb_lowest_pick #(.N(NUM_FU)) u_rd_pick (
    .req (rd_req_v),
    .gnt (rd_grant)
  );

  sb_lowest_pick #(.N(NUM_FU)) u_wr_pick (
    .req (fin_v & war_ok_v),
    .gnt (wr_grant)
  );

  assign wr_any = |wr_grant;

  always_comb begin
    wr_idx = '0;
    wr_reg = '0;
    for (int i = 0; i < NUM_FU; i++) begin
      if (wr_grant[i]) begin
        wr_idx = FU_W'(i);
        wr_reg = dst_arr[i];
      end
    end
  end

endmodule

// File: rtl/sb_sched_chk.sv
module sb_sched_chk #(
  parameter int NUM_FU = 5,
  parameter int FU_W   = 3,
  parameter int REG_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              iss_valid,
  input logic [FU_W-1:0]   iss_unit,
  input logic [REG_W-1:0]  iss_dst,
  input logic              iss_stall,
  input logic [NUM_FU-1:0] rd_grant,
  input logic [NUM_FU-1:0] wr_grant
);

  // R2
  stall_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_stall |-> iss_valid);

  // R6
  one_reader_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rd_grant));

  // R9
  one_writer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_grant));

  // R6
  single_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_grant != '0) |=> ((rd_grant & $past(rd_grant)) == '0));

  // R7
  no_write_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_grant != '0) |=> ((wr_grant & $past(rd_grant)) == '0));

  // R10
  no_reissue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !iss_stall) |=>
      !(iss_valid && !iss_stall && (iss_unit == $past(iss_unit))));

  // R3
  no_waw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !iss_stall) |=>
      !(iss_valid && !iss_stall && (iss_dst == $past(iss_dst))));

endmodule

bind scoreboard_ctl sb_sched_chk #(
  .NUM_FU (NUM_FU),
  .FU_W   (FU_W),
  .REG_W  (REG_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .iss_valid (iss_valid),
  .iss_unit  (iss_unit),
  .iss_dst   (iss_dst),
  .iss_stall (iss_stall),
  .rd_grant  (rd_grant),
  .wr_grant  (wr_grant)
);

// File: tb/sim_scoreboard_ctl.sv
module sim_scoreboard_ctl;

  localparam int NFU  = 5;
  localparam int NREG = 32;
  localparam int FW   = 3;
  localparam int RW   = 5;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           iss_valid = 1'b0;
  logic [FW-1:0]  iss_unit = '0;
  logic [RW-1:0]  iss_dst = '0, iss_src_a = '0, iss_src_b = '0;
  logic [NFU-1:0] unit_done = '0;
  logic           iss_stall;
  logic [NFU-1:0] rd_grant, wr_grant;
  logic [RW-1:0]  wr_reg;

  always #5 clk = ~clk;

  scoreboard_ctl #(.NUM_FU(NFU), .NUM_REG(NREG)) u0 (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_unit(iss_unit),
    .iss_dst(iss_dst), .iss_src_a(iss_src_a), .iss_src_b(iss_src_b),
    .iss_stall(iss_stall), .unit_done(unit_done), .rd_grant(rd_grant),
    .wr_grant(wr_grant), .wr_reg(wr_reg)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Behavioural model built from the requirements
  bit m_busy [NFU];
  bit m_read [NFU];
  bit m_fin  [NFU];
  int m_dst  [NFU];
  int m_sa   [NFU];
  int m_sb   [NFU];
  bit m_qav  [NFU];
  bit m_qbv  [NFU];
  int m_qa   [NFU];
  int m_qb   [NFU];
  bit m_pv   [NREG];
  int m_pf   [NREG];

  logic           o_stall;
  logic [NFU-1:0] o_rd, o_wr;
  logic [RW-1:0]  o_wreg;

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got=%0d expected=%0d at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic bit m_ready_a(int f);
    return m_busy[f] && !m_read[f] && !m_qav[f];
  endfunction

  function automatic bit m_ready_b(int f);
    return m_busy[f] && !m_read[f] && !m_qbv[f];
  endfunction

  function automatic int exp_reader();
    for (int u = 0; u < NFU; u++)
      if (m_ready_a(u) && m_ready_b(u)) return u;
    return -1;
  endfunction

  function automatic int exp_writer();
    for (int u = 0; u < NFU; u++) begin
      if (m_fin[u]) begin
        bit blocked = 0;
        for (int f = 0; f < NFU; f++)
          if (f != u && ((m_ready_a(f) && m_sa[f] == m_dst[u]) ||
                         (m_ready_b(f) && m_sb[f] == m_dst[u])))
            blocked = 1;
        if (!blocked) return u;
      end
    end
    return -1;
  endfunction

  task automatic model_reset();
    for (int u = 0; u < NFU; u++) begin
      m_busy[u] = 0; m_read[u] = 0; m_fin[u] = 0;
      m_qav[u] = 0;  m_qbv[u] = 0;
      m_dst[u] = 0;  m_sa[u] = 0;  m_sb[u] = 0; m_qa[u] = 0; m_qb[u] = 0;
    end
    for (int r = 0; r < NREG; r++) begin
      m_pv[r] = 0; m_pf[r] = 0;
    end
  endtask

  // One cycle: drive after the falling edge, compare, advance the model
  task automatic step(input bit v, input int u, input int d, input int a,
                      input int b, input logic [NFU-1:0] dn);
    bit e_stall, acc, qav, qbv;
    int e_rd, e_wr, qa, qb;
    logic [NFU-1:0] rdv, wrv;
    bit done_ok [NFU];
    @(negedge clk);
    iss_valid = v;
    iss_unit  = FW'(u);
    iss_dst   = RW'(d);
    iss_src_a = RW'(a);
    iss_src_b = RW'(b);
    unit_done = dn;
    #1;
    e_stall = v && (m_busy[u] || m_pv[d]);
    e_rd = exp_reader();
    e_wr = exp_writer();
    rdv = '0; wrv = '0;
    if (e_rd >= 0) rdv[e_rd] = 1'b1;
    if (e_wr >= 0) wrv[e_wr] = 1'b1;
    chk("R2 R3 R4 issue stall", int'(iss_stall), int'(e_stall));
    chk("R5 R6 read grant", int'(rd_grant), int'(rdv));
    chk("R7 R8 R9 write grant", int'(wr_grant), int'(wrv));
    if (e_wr >= 0) chk("R9 write register", int'(wr_reg), m_dst[e_wr]);
    o_stall = iss_stall; o_rd = rd_grant; o_wr = wr_grant; o_wreg = wr_reg;
    // issue view of the sources uses the state before this edge
    acc = v && !e_stall;
    qav = m_pv[a] && !(e_wr >= 0 && m_pf[a] == e_wr);
    qbv = m_pv[b] && !(e_wr >= 0 && m_pf[b] == e_wr);
    qa = m_pf[a]; qb = m_pf[b];
    for (int f = 0; f < NFU; f++)
      done_ok[f] = dn[f] && m_busy[f] && m_read[f] && !m_fin[f];
    if (e_wr >= 0) begin
      m_busy[e_wr] = 0; m_fin[e_wr] = 0; m_read[e_wr] = 0;
      m_pv[m_dst[e_wr]] = 0;
      for (int f = 0; f < NFU; f++) begin
        if (m_busy[f] && !m_read[f] && m_qav[f] && m_qa[f] == e_wr) m_qav[f] = 0;
        if (m_busy[f] && !m_read[f] && m_qbv[f] && m_qb[f] == e_wr) m_qbv[f] = 0;
      end
    end
    if (e_rd >= 0) m_read[e_rd] = 1;
    for (int f = 0; f < NFU; f++) if (done_ok[f]) m_fin[f] = 1;
    if (acc) begin
      m_busy[u] = 1; m_read[u] = 0; m_fin[u] = 0;
      m_dst[u] = d; m_sa[u] = a; m_sb[u] = b;
      m_qav[u] = qav; m_qbv[u] = qbv; m_qa[u] = qa; m_qb[u] = qb;
      m_pv[d] = 1; m_pf[d] = u;
    end
  endtask

  task automatic idle(input logic [NFU-1:0] dn);
    step(0, 0, 0, 0, 0, dn);
  endtask

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    idle('0);
    chk("R1 stall after reset", int'(o_stall), 0);
    chk("R1 read grant after reset", int'(o_rd), 0);
    chk("R1 write grant after reset", int'(o_wr), 0);

    // R5 R6 R7 R9 R10 R11: dependent add behind a multiply
    step(1, 2, 1, 2, 3, '0);
    step(1, 1, 4, 1, 5, '0);
    chk("R6 read one cycle after issue", int'(o_rd), 'b00100);
    step(0, 0, 0, 0, 0, 5'b00100);
    chk("R5 consumer held before producer write", int'(o_rd), 0);
    step(1, 0, 10, 1, 0, '0);
    chk("R7 write granted cycle after done", int'(o_wr), 'b00100);
    chk("R9 written register", int'(o_wreg), 1);
    chk("R11 issue during producer write accepted", int'(o_stall), 0);
    step(1, 2, 7, 8, 9, '0);
    chk("R10 unit reissued after its write", int'(o_stall), 0);
    chk("R6 R11 lowest ready unit reads first", int'(o_rd), 'b00001);
    idle('0);
    chk("R5 consumer reads after producer write", int'(o_rd), 'b00010);
    idle('0);
    chk("R6 next reader", int'(o_rd), 'b00100);
    idle(5'b00111);
    idle('0);
    chk("R9 lowest finished unit writes first", int'(o_wr), 'b00001);
    idle('0);
    chk("R9 second writer", int'(o_wr), 'b00010);
    idle('0);
    chk("R9 third writer", int'(o_wr), 'b00100);

    // R3 R4 R10: destination conflict and in-order hold
    step(1, 0, 5, 1, 2, '0);
    step(1, 1, 5, 3, 4, '0);
    chk("R3 same destination stalls", int'(o_stall), 1);
    step(1, 1, 5, 3, 4, 5'b00001);
    chk("R4 stalled unit gets no grant", int'(o_rd[1]), 0);
    step(1, 1, 5, 3, 4, '0);
    chk("R3 stall held during older write", int'(o_stall), 1);
    step(1, 1, 5, 3, 4, '0);
    chk("R3 R4 accepted after older write", int'(o_stall), 0);
    step(0, 0, 0, 0, 0, 5'b11110);
    chk("R6 read of reissued unit", int'(o_rd), 'b00010);
    idle('0);
    chk("R7 early done strobe ignored", int'(o_wr), 0);
    idle(5'b00010);
    idle('0);
    chk("R7 write after real done", int'(o_wr), 'b00010);

    // R2 busy unit stall
    step(1, 4, 12, 13, 14, '0);
    step(1, 4, 20, 21, 22, '0);
    chk("R2 busy unit stalls", int'(o_stall), 1);
    // R8: anti-dependence block
    step(1, 1, 15, 12, 16, '0);
    step(1, 0, 16, 17, 18, '0);
    idle('0);
    chk("R6 independent unit reads", int'(o_rd), 'b00001);
    idle(5'b00001);
    idle('0);
    chk("R8 write blocked by unread reader", int'(o_wr), 0);
    idle(5'b10000);
    idle('0);
    chk("R8 unrelated writer proceeds", int'(o_wr), 'b10000);
    idle('0);
    chk("R5 reader released", int'(o_rd), 'b00010);
    chk("R8 still blocked while reader unread", int'(o_wr), 0);
    idle('0);
    chk("R8 write after reader took operand", int'(o_wr), 'b00001);
    chk("R9 blocked writer register", int'(o_wreg), 16);
    idle(5'b00010);
    idle('0);
    idle('0);

    // Constrained random stream with dense hazards
    begin
      bit has = 0;
      int cu = 0, cd = 0, ca = 0, cb = 0;
      void'($urandom(32'h5c0b));
      for (int n = 0; n < 4000; n++) begin
        logic [NFU-1:0] dn = '0;
        if (!has && $urandom_range(0, 9) < 7) begin
          has = 1;
          cu = $urandom_range(0, NFU - 1);
          cd = $urandom_range(0, 7);
          ca = $urandom_range(0, 7);
          cb = $urandom_range(0, 7);
        end
        for (int f = 0; f < NFU; f++) begin
          if (m_busy[f] && m_read[f] && !m_fin[f] && $urandom_range(0, 9) < 4) dn[f] = 1'b1;
          if ($urandom_range(0, 19) == 0) dn[f] = 1'b1;
        end
        step(has, cu, cd, ca, cb, dn);
        if (has && !o_stall) has = 0;
      end
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired got=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule